// File: doc/BRIEF.md
# Exposure and Flush Arbiter

This block sits between a host controller and a linear image sensor. It turns host request strobes into sensor control pulses. It forwards a request only when the sensor can accept it. Exposure and pixel flush lock each other out. The readout settling window (CDS) is kept apart from both the flush window and the post-exposure shift. A data-clear that arrives while a shift is running is held back until the shift has finished.

While the host reports that the sensor is idle, the block also acts on its own. It issues a pixel flush at least once per configured period, and it clears the frame store when no exposure, readout or clear has started for a long time. With the default parameters and a 100 MHz clock, that timeout is 100 ms. Host requests always win over these automatic actions. An automatic flush that falls due during an exposure waits until the shift has ended.

Each request the block turns down raises a rejection flag for one cycle. All sensor outputs are registered. Every interval is a parameter counted in system clock cycles.

Top module: `eflush_arb`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all sensor outputs and all rejection flags are low.
- R2: An accepted shutter request drives `sen_shutter` high for exactly EXPOSE_CYC cycles, starting in the cycle after the request. A shift period of SHIFT_CYC cycles follows at once.
- R3: A shutter request is rejected if it arrives during the FLUSH_CYC cycles that follow a flush start, including the last of them. It is also rejected during an exposure, a shift or a CDS window. `shut_rej` is high in the cycle after a rejected request.
- R4: A flush request is rejected, with `flush_rej` high in the next cycle, while `sen_shutter` is high and during the shift period that follows.
- R5: An accepted read request starts a `sen_read` pulse and a CDS window of CDS_CYC cycles. A read request is rejected (`read_rej`) during a flush window, an exposure, a shift or a CDS window. Flush and shutter requests are rejected during a CDS window.
- R6: When several requests arrive in the same cycle, the shutter is taken first, the flush second and the read last. The requests that lose are flagged as rejected.
- R7: A shutter request and a clear request in the same cycle are both forwarded. `sen_shutter` and `sen_clear` rise together.
- R8: A clear request that arrives during a shift is held. `sen_clear` rises two cycles after the last shift cycle.
- R9: The `sen_flush`, `sen_clear` and `sen_read` pulses each last exactly PULSE_W cycles.
- R10: While `idle` is high and nothing blocks, automatic flush pulses start exactly FLUSH_PERIOD cycles apart.
- R11: An automatic flush that falls due during an exposure or shift is issued in the first cycle after the shift ends. `sen_flush` is high in the cycle after that.
- R12: While `idle` is high, an automatic clear starts IDLE_CLR_CYC cycles after the last accepted shutter, accepted read or clear start.
- R13: While `idle` is low, no automatic flush or clear is issued. When `idle` rises with both timers expired, `sen_flush` and `sen_clear` both go high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle | input | 1 | Host reports no acquisition in progress; enables automatic actions |
| shut_req | input | 1 | Host shutter request strobe |
| flush_req | input | 1 | Host pixel-flush request strobe |
| read_req | input | 1 | Host readout (CDS start) request strobe |
| clear_req | input | 1 | Host frame-store clear request strobe |
| sen_shutter | output | 1 | Sensor shutter, high for the exposure |
| sen_flush | output | 1 | Sensor pixel-flush pulse |
| sen_read | output | 1 | Sensor read pulse that starts the CDS window |
| sen_clear | output | 1 | Sensor data-clear pulse |
| shut_rej | output | 1 | Shutter request was rejected (one cycle) |
| flush_rej | output | 1 | Flush request was rejected (one cycle) |
| read_rej | output | 1 | Read request was rejected (one cycle) |

## Verification
The hardest case to reach is an automatic flush that falls due in the middle of an exposure. The flush timer cannot be observed directly, so the stimulus first waits for an automatic flush to appear. That event marks the timer's zero point. The bench then starts a shutter a few cycles before the next due point and checks that no flush appears until the cycle just after the shift ends. A second hard case is a clear request that lands inside the shift period, which is not visible at the ports. The bench places it by counting cycles from the shutter request.

// File: rtl/eflush_pkg.sv
package eflush_pkg;

    // indices of the simple timed windows built in the generate loop
    localparam int W_FLWIN = 0;  // flush lockout window
    localparam int W_CDS   = 1;  // readout settling window
    localparam int W_FLP   = 2;  // flush pulse
    localparam int W_CLRP  = 3;  // clear pulse
    localparam int W_RDP   = 4;  // read pulse
    localparam int NWIN    = 5;

    typedef struct packed {
        logic clr_pend;
        logic shut_rej;
        logic flush_rej;
        logic read_rej;
    } arb_st_t;

endpackage

// File: rtl/eflush_win.sv
module eflush_win #(
    parameter int unsigned LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    localparam int W = $clog2(LEN + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = W'(LEN);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);

    // R9: a window is never restarted while still running
    a_r9_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active);

endmodule

// File: rtl/eflush_phase.sv
module eflush_phase #(
    parameter int unsigned EXPOSE_CYC = 8,
    parameter int unsigned SHIFT_CYC  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expo,
    output logic shift
);
    localparam int unsigned TOTAL = EXPOSE_CYC + SHIFT_CYC;
    localparam int W = $clog2(TOTAL + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = W'(TOTAL);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expo  = (cnt_q > W'(SHIFT_CYC));
    assign shift = (cnt_q != '0) && (cnt_q <= W'(SHIFT_CYC));

    // R2: shift directly follows the end of exposure
    a_r2_shift_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(expo) |-> shift);

    // R2: exposure only starts from a quiet phase
    a_r2_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !(expo || shift));

endmodule

// File: rtl/eflush_tick.sv
module eflush_tick #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic due
);
    localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);

    logic [W-1:0] cnt_d, cnt_q;

    assign due = (cnt_q == W'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (!due) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R10: once due, the timer stays due until it is restarted
    a_r10_due_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (due && !clr) |=> due);

endmodule

// File: rtl/eflush_arb.sv
module eflush_arb #(
    parameter int unsigned EXPOSE_CYC   = 1000,
    parameter int unsigned SHIFT_CYC    = 200,
    parameter int unsigned FLUSH_CYC    = 500,
    parameter int unsigned CDS_CYC      = 300,
    parameter int unsigned PULSE_W      = 20,
    parameter int unsigned FLUSH_PERIOD = 1000000,
    parameter int unsigned IDLE_CLR_CYC = 10000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic idle,
    input  logic shut_req,
    input  logic flush_req,
    input  logic read_req,
    input  logic clear_req,
    output logic sen_shutter,
    output logic sen_flush,
    output logic sen_read,
    output logic sen_clear,
    output logic shut_rej,
    output logic flush_rej,
    output logic read_rej
);
    import eflush_pkg::*;

    localparam int unsigned WLEN [NWIN] = '{FLUSH_CYC, CDS_CYC, PULSE_W, PULSE_W, PULSE_W};

    arb_st_t st_d, st_q;

    logic [NWIN-1:0] wstart, wact;
    logic ph_expo, ph_shift;
    logic busy, lock;
    logic shut_ok, fl_ok, rd_ok, af_go, fl_go;
    logic clr_want, clr_go;
    logic fl_due, ic_due, ic_clr;

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        eflush_win #(.LEN(WLEN[i])) u_win (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (wstart[i]),
            .active (wact[i])
        );
    end

    eflush_phase #(.EXPOSE_CYC(EXPOSE_CYC), .SHIFT_CYC(SHIFT_CYC)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .start (shut_ok),
        .expo  (ph_expo),
        .shift (ph_shift)
    );

    eflush_tick #(.LIMIT(FLUSH_PERIOD)) u_fl_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fl_go),
        .due   (fl_due)
    );

    eflush_tick #(.LIMIT(IDLE_CLR_CYC)) u_ic_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ic_clr),
        .due   (ic_due)
    );

    always_comb begin
        busy    = ph_expo | ph_shift;
        lock    = busy | wact[W_FLWIN] | wact[W_CDS];

        // host requests, shutter first, flush second, read last
        shut_ok = shut_req & ~lock;
        fl_ok   = flush_req & ~lock & ~shut_ok;
        rd_ok   = read_req & ~lock & ~shut_ok & ~fl_ok;

        // automatic flush only in a cycle with no host request
        af_go   = idle & fl_due & ~lock & ~shut_req & ~flush_req & ~read_req;
        fl_go   = fl_ok | af_go;

        // clear: held while a shift runs or a clear pulse is out
        clr_want = clear_req | st_q.clr_pend | (idle & ic_due);
        clr_go   = clr_want & ~ph_shift & ~wact[W_CLRP];
        ic_clr   = shut_ok | rd_ok | clr_go;

        st_d.clr_pend  = (clear_req | st_q.clr_pend) & ~clr_go;
        st_d.shut_rej  = shut_req & ~shut_ok;
        st_d.flush_rej = flush_req & ~fl_ok;
        st_d.read_rej  = read_req & ~rd_ok;

        wstart          = '0;
        wstart[W_FLWIN] = fl_go;
        wstart[W_FLP]   = fl_go;
        wstart[W_CDS]   = rd_ok;
        wstart[W_RDP]   = rd_ok;
        wstart[W_CLRP]  = clr_go;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sen_shutter = ph_expo;
    assign sen_flush   = wact[W_FLP];
    assign sen_read    = wact[W_RDP];
    assign sen_clear   = wact[W_CLRP];
    assign shut_rej    = st_q.shut_rej;
    assign flush_rej   = st_q.flush_rej;
    assign read_rej    = st_q.read_rej;

    // R3: shutter never starts inside a flush lockout window
    a_r3_shut_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sen_shutter) |-> !$past(wact[W_FLWIN]));

    // R3: a rejection flag never comes with a starting exposure
    a_r3_rej_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        shut_rej |-> !$rose(sen_shutter));

    // R4: flush never starts during exposure or shift
    a_r4_flush_vs_expo: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sen_flush) |-> !$past(ph_expo || ph_shift));

    // R5: CDS overlaps neither the flush window nor the shift
    a_r5_no_cds_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(wact[W_CDS] && (wact[W_FLWIN] || ph_shift)));

    // R6: at most one of shutter, flush, read starts in any cycle
    a_r6_one_start: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({$rose(sen_shutter), $rose(sen_flush), $rose(sen_read)}));

    // R8: the clear pulse never starts while a shift is running
    a_r8_clear_not_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sen_clear) |-> !$past(ph_shift));

endmodule

// File: tb/eflush_arb_bench.sv
module eflush_arb_bench;

    localparam int CLK_PERIOD = 10;
    localparam int EXP  = 6;
    localparam int SHF  = 4;
    localparam int FLW  = 5;
    localparam int CDSW = 5;
    localparam int PW   = 2;
    localparam int FPER = 40;
    localparam int ICLR = 100;
    localparam int WDOG = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic idle = 1'b0;
    logic shut_req = 1'b0, flush_req = 1'b0, read_req = 1'b0, clear_req = 1'b0;
    logic sen_shutter, sen_flush, sen_read, sen_clear;
    logic shut_rej, flush_rej, read_rej;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eflush_arb #(
        .EXPOSE_CYC(EXP), .SHIFT_CYC(SHF), .FLUSH_CYC(FLW), .CDS_CYC(CDSW),
        .PULSE_W(PW), .FLUSH_PERIOD(FPER), .IDLE_CLR_CYC(ICLR)
    ) u_eflush_arb (
        .clk(clk), .rst_n(rst_n), .idle(idle),
        .shut_req(shut_req), .flush_req(flush_req), .read_req(read_req), .clear_req(clear_req),
        .sen_shutter(sen_shutter), .sen_flush(sen_flush), .sen_read(sen_read), .sen_clear(sen_clear),
        .shut_rej(shut_rej), .flush_rej(flush_rej), .read_rej(read_rej)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected under %0d", cyc, WDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic idle_v);
        rst_n = 1'b0;
        idle = idle_v;
        {shut_req, flush_req, read_req, clear_req} = '0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    function automatic logic pick(input int sel);
        return (sel == 0) ? sen_flush : sen_clear;
    endfunction

    // steps until a rising edge of the chosen output; returns cycles waited
    task automatic wait_rise(input int sel, output int n);
        logic prev;
        prev = pick(sel);
        n = 0;
        for (int k = 0; k < 500; k++) begin
            step(1);
            n++;
            if (pick(sel) && !prev) return;
            prev = pick(sel);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        step(2);
        chk({sen_shutter, sen_flush, sen_read, sen_clear, shut_rej, flush_rej, read_rej} == '0,
            "R1 outputs low in reset", int'(sen_shutter | sen_flush | sen_clear), 0);
        do_reset(1'b0);
        chk({sen_shutter, sen_flush, sen_read, sen_clear, shut_rej, flush_rej, read_rej} == '0,
            "R1 outputs low after reset", int'(sen_shutter | sen_flush | sen_clear), 0);
    endtask

    task automatic t_shutter;
        int hi;
        do_reset(1'b0);
        shut_req = 1'b1; step(1); shut_req = 1'b0;
        hi = 0;
        for (int k = 0; k < 12; k++) begin
            if (sen_shutter) hi++;
            step(1);
        end
        chk(hi == EXP, "R2 exposure length", hi, EXP);
    endtask

    task automatic t_flush_window;
        do_reset(1'b0);
        flush_req = 1'b1; step(1); flush_req = 1'b0;
        chk(sen_flush == 1'b1, "R9 flush pulse out", int'(sen_flush), 1);
        shut_req = 1'b1; step(1); shut_req = 1'b0;
        chk(shut_rej && !sen_shutter, "R3 shutter in flush window", int'(shut_rej), 1);
        step(3);
        shut_req = 1'b1; step(1); shut_req = 1'b0;
        chk(shut_rej && !sen_shutter, "R3 shutter on last window cycle", int'(shut_rej), 1);
        shut_req = 1'b1; step(1); shut_req = 1'b0;
        chk(sen_shutter && !shut_rej, "R3 shutter after window", int'(sen_shutter), 1);
    endtask

    task automatic t_flush_block;
        do_reset(1'b0);
        shut_req = 1'b1; step(1); shut_req = 1'b0;
        step(1);
        flush_req = 1'b1; step(1); flush_req = 1'b0;
        chk(flush_rej && !sen_flush, "R4 flush during exposure", int'(flush_rej), 1);
        step(5);
        flush_req = 1'b1; step(1); flush_req = 1'b0;
        chk(flush_rej && !sen_shutter, "R4 flush during shift", int'(flush_rej), 1);
        step(1);
        flush_req = 1'b1; step(1); flush_req = 1'b0;
        chk(flush_rej == 1'b1, "R4 flush on last shift cycle", int'(flush_rej), 1);
        flush_req = 1'b1; step(1); flush_req = 1'b0;
        chk(sen_flush && !flush_rej, "R4 flush after shift", int'(sen_flush), 1);
    endtask

    task automatic t_cds;
        do_reset(1'b0);
        read_req = 1'b1; step(1); read_req = 1'b0;
        chk(sen_read == 1'b1, "R5 read pulse out", int'(sen_read), 1);
        flush_req = 1'b1; step(1); flush_req = 1'b0;
        chk(flush_rej && !sen_flush, "R5 flush during CDS", int'(flush_rej), 1);
        chk(sen_read == 1'b1, "R9 read pulse second cycle", int'(sen_read), 1);
        shut_req = 1'b1; step(1); shut_req = 1'b0;
        chk(shut_rej && !sen_shutter, "R5 shutter during CDS", int'(shut_rej), 1);
        chk(sen_read == 1'b0, "R9 read pulse width", int'(sen_read), 0);
        step(2);
        flush_req = 1'b1; step(1); flush_req = 1'b0;
        chk(flush_rej == 1'b1, "R5 flush on last CDS cycle", int'(flush_rej), 1);
        flush_req = 1'b1; step(1); flush_req = 1'b0;
        chk(sen_flush == 1'b1, "R5 flush after CDS", int'(sen_flush), 1);
        read_req = 1'b1; step(1); read_req = 1'b0;
        chk(read_rej && !sen_read, "R5 read during flush window", int'(read_rej), 1);
    endtask

    task automatic t_priority;
        do_reset(1'b0);
        {shut_req, flush_req, read_req} = 3'b111; step(1); {shut_req, flush_req, read_req} = '0;
        chk(sen_shutter && !sen_flush && !sen_read, "R6 shutter wins", int'(sen_shutter), 1);
        chk(flush_rej && read_rej && !shut_rej, "R6 losers flagged", int'(flush_rej & read_rej), 1);
        do_reset(1'b0);
        {flush_req, read_req} = 2'b11; step(1); {flush_req, read_req} = '0;
        chk(sen_flush && !sen_read && read_rej, "R6 flush over read", int'(sen_flush), 1);
    endtask

    task automatic t_shut_clear;
        do_reset(1'b0);
        {shut_req, clear_req} = 2'b11; step(1); {shut_req, clear_req} = '0;
        chk(sen_shutter && sen_clear, "R7 shutter and clear together",
            int'({sen_shutter, sen_clear}), 3);
    endtask

    task automatic t_clear_hold;
        do_reset(1'b0);
        shut_req = 1'b1; step(1); shut_req = 1'b0;
        step(7);
        clear_req = 1'b1; step(1); clear_req = 1'b0;
        chk(sen_clear == 1'b0, "R8 clear held in shift", int'(sen_clear), 0);
        step(2);
        chk(sen_clear == 1'b0, "R8 clear held after last shift", int'(sen_clear), 0);
        step(1);
        chk(sen_clear == 1'b1, "R8 clear released", int'(sen_clear), 1);
        step(1);
        chk(sen_clear == 1'b1, "R9 clear second cycle", int'(sen_clear), 1);
        step(1);
        chk(sen_clear == 1'b0, "R9 clear width", int'(sen_clear), 0);
    endtask

    task automatic t_auto_flush;
        int n;
        do_reset(1'b1);
        wait_rise(0, n);
        wait_rise(0, n);
        chk(n == FPER, "R10 auto flush period", n, FPER);
    endtask

    task automatic t_defer;
        int n;
        int seen;
        do_reset(1'b1);
        wait_rise(0, n);
        step(35);
        shut_req = 1'b1; step(1); shut_req = 1'b0;
        seen = 0;
        for (int k = 0; k < 11; k++) begin
            if (sen_flush) seen++;
            step(1);
        end
        chk(seen == 0, "R11 no flush during exposure", seen, 0);
        chk(sen_flush == 1'b1, "R11 deferred flush after shift", int'(sen_flush), 1);
    endtask

    task automatic t_idle_clear;
        int n;
        do_reset(1'b1);
        wait_rise(1, n);
        wait_rise(1, n);
        chk(n == ICLR, "R12 idle clear interval", n, ICLR);
        step(50);
        read_req = 1'b1; step(1); read_req = 1'b0;
        wait_rise(1, n);
        chk(n == ICLR, "R12 read restarts idle clear", n + 51, ICLR + 51);
    endtask

    task automatic t_idle_low;
        int seen;
        do_reset(1'b0);
        seen = 0;
        for (int k = 0; k < 120; k++) begin
            if (sen_flush || sen_clear) seen++;
            step(1);
        end
        chk(seen == 0, "R13 nothing automatic while busy", seen, 0);
        idle = 1'b1;
        step(1);
        chk(sen_flush && sen_clear, "R13 both issue on idle", int'({sen_flush, sen_clear}), 3);
    endtask

    initial begin
        step(1);
        t_reset();
        t_shutter();
        t_flush_window();
        t_flush_block();
        t_cds();
        t_priority();
        t_shut_clear();
        t_clear_hold();
        t_auto_flush();
        t_defer();
        t_idle_clear();
        t_idle_low();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule